// File: doc/BRIEF.md
# Fuse Programming Pulse Sequencer

This block burns a single bit of a one-time-programmable memory organised as 512 words of 4 bits. A request gives a word address and the index of one output bit. The sequencer then steps through a fixed, timed handshake. It puts the supply selector at the low programming level, holds the chip disabled with its outputs clamped, and raises the supply to the programming level. After a settling delay it drives one programming pulse onto the chosen output line only. It then waits, drops the supply, enables the chip at the verify level and samples the chosen data line. An intact fuse reads high. A blown fuse reads low.

Every interval is a whole number of ticks of a 1 µs enable strobe, so the same logic runs at any clock rate. The block never retries. A bit that still reads high after its single pulse is reported as a reject. A cool-down interval, sized when the design is elaborated, stretches each sequence so that the pulse-on time never exceeds the configured duty-cycle percentage of the whole sequence.

The analog level drivers outside the block decode the supply selector, chip-enable, clamp and pulse outputs. The address lines are driven from a register at all times.

Top module: `fuse_prog_seq`

## Requirements
- R1: After reset the block is idle: busy, done, passFlag, rejectFlag, chipEnable, outClamp and pulseOut are all 0, supplySel is 2'b00 (low programming level) and addrOut is 0.
- R2: A start is accepted only while busy is 0. reqAddr and reqBit are captured on that edge. A start raised while busy is 1 has no effect on addrOut, on the pulsed bit, on the sequence length or on the number of done pulses.
- R3: A sequence begins with SETUP_TICKS ticks at supplySel 2'b00 with chipEnable 0 and outClamp 1. It then spends RISE_TICKS plus DELAY1_TICKS ticks at supplySel 2'b01 (programming level) before the pulse starts. The pulse occurs only at supplySel 2'b01 with chipEnable 0.
- R4: Exactly one pulse is driven, lasting PULSE_TICKS ticks. During it pulseOut is one-hot, with bit reqBit set (bit i of pulseOut drives data line i).
- R5: After the pulse the supply stays at 2'b01 for DELAY2_TICKS ticks and then sits at 2'b00 for FALL_TICKS ticks. Verification follows for VERIFY_TICKS ticks with chipEnable 1, supplySel 2'b10 and no pulse.
- R6: At the end of the verify window, senseData[reqBit] equal to 0 sets passFlag and equal to 1 sets rejectFlag. Other senseData bits have no effect. The two flags are never both set, and no second pulse is issued in one sequence.
- R7: From acceptance to done, the sequence spans max(ceil(PULSE_TICKS*100/DUTY_PCT), sum of the phase lengths) ticks. Idle cool-down ticks with supplySel 2'b00 and chipEnable 0 fill the difference.
- R8: addrOut equals the captured address for the whole sequence and is never undriven.
- R9: done is a single-cycle pulse, one per sequence. passFlag and rejectFlag keep their value after done until the next accepted start clears them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| usTick | input | 1 | One-cycle enable strobe every 1 µs |
| start | input | 1 | Request to program one bit |
| reqAddr | input | ADDR_W | Word address to program |
| reqBit | input | $clog2(NUM_BITS) | Index of the output bit to blow |
| senseData | input | NUM_BITS | Sampled data lines of the memory |
| addrOut | output | ADDR_W | Address lines to the memory |
| supplySel | output | 2 | Supply level: 00 low, 01 program, 10 verify |
| chipEnable | output | 1 | 1 enables the memory outputs |
| outClamp | output | 1 | 1 holds the data lines at the disable level |
| pulseOut | output | NUM_BITS | Programming pulse, one bit per data line |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| passFlag | output | 1 | Bit verified as blown |
| rejectFlag | output | 1 | Bit still intact after its single pulse |

## Verification
The assertions assume that usTick is a single-cycle strobe and that reset is held for at least one clock before the first request. They place no constraint on start during a sequence, because the block must ignore it. The stimulus generates usTick every fourth clock from a free divider. It raises start for one cycle when idle, and once deliberately during a pulse. senseData is held constant for each sequence, with the selected bit set or cleared and the other bits given the opposite value, so that only the selected line can explain the verdict.

// File: rtl/fps_pkg.sv
package fps_pkg;

  typedef enum logic [3:0] {
    PH_IDLE, PH_SETUP, PH_RISE, PH_DLY1, PH_PULSE,
    PH_DLY2, PH_FALL, PH_VERIFY, PH_COOL, PH_DONE
  } phase_e;

  localparam logic [1:0] SUP_LOW  = 2'b00;
  localparam logic [1:0] SUP_PROG = 2'b01;
  localparam logic [1:0] SUP_VFY  = 2'b10;

  // strobes from control to datapath
  typedef struct packed {
    logic       latch;    // capture request, clear verdict
    logic       sample;   // judge the sensed bit
    logic       pulseEn;  // drive the programming pulse
    logic       chipEn;   // enable chip for read
    logic       clamp;    // hold data lines at disable level
    logic [1:0] supply;   // supply level select
  } strobe_t;

endpackage

// File: rtl/fps_ctrl.sv
module fps_ctrl
  import fps_pkg::*;
#(
  parameter int CW           = 9,
  parameter int SETUP_TICKS  = 2,
  parameter int RISE_TICKS   = 5,
  parameter int DELAY1_TICKS = 10,
  parameter int PULSE_TICKS  = 100,
  parameter int DELAY2_TICKS = 5,
  parameter int FALL_TICKS   = 5,
  parameter int VERIFY_TICKS = 5,
  parameter int COOL_TICKS   = 0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          expire,
  output strobe_t       stb,
  output logic [CW-1:0] phaseLen,
  output logic          busy,
  output logic          done
);

  phase_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= PH_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      PH_IDLE:   if (start)  nextState = PH_SETUP;
      PH_SETUP:  if (expire) nextState = PH_RISE;
      PH_RISE:   if (expire) nextState = PH_DLY1;
      PH_DLY1:   if (expire) nextState = PH_PULSE;
      PH_PULSE:  if (expire) nextState = PH_DLY2;
      PH_DLY2:   if (expire) nextState = PH_FALL;
      PH_FALL:   if (expire) nextState = PH_VERIFY;
      PH_VERIFY: if (expire) nextState = PH_COOL;
      PH_COOL:   if (expire) nextState = PH_DONE;
      PH_DONE:               nextState = PH_IDLE;
      default:               nextState = PH_IDLE;
    endcase
  end

  always_comb begin
    unique case (state)
      PH_SETUP:  phaseLen = CW'(SETUP_TICKS);
      PH_RISE:   phaseLen = CW'(RISE_TICKS);
      PH_DLY1:   phaseLen = CW'(DELAY1_TICKS);
      PH_PULSE:  phaseLen = CW'(PULSE_TICKS);
      PH_DLY2:   phaseLen = CW'(DELAY2_TICKS);
      PH_FALL:   phaseLen = CW'(FALL_TICKS);
      PH_VERIFY: phaseLen = CW'(VERIFY_TICKS);
      PH_COOL:   phaseLen = CW'(COOL_TICKS);
      default:   phaseLen = '0;
    endcase
  end

  always_comb begin
    stb.latch   = (state == PH_IDLE) && start;
    stb.sample  = (state == PH_VERIFY) && expire;
    stb.pulseEn = (state == PH_PULSE);
    stb.chipEn  = (state == PH_VERIFY);
    stb.clamp   = (state inside {PH_SETUP, PH_RISE, PH_DLY1, PH_PULSE, PH_DLY2, PH_FALL});
    if (state inside {PH_RISE, PH_DLY1, PH_PULSE, PH_DLY2}) stb.supply = SUP_PROG;
    else if (state == PH_VERIFY)                            stb.supply = SUP_VFY;
    else                                                    stb.supply = SUP_LOW;
  end

  assign busy = (state != PH_IDLE);
  assign done = (state == PH_DONE);

endmodule

// File: rtl/fps_dpath.sv
module fps_dpath
  import fps_pkg::*;
#(
  parameter int AW = 9,
  parameter int NB = 4,
  parameter int CW = 9,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          usTick,
  input  strobe_t       stb,
  input  logic [CW-1:0] phaseLen,
  input  logic [AW-1:0] reqAddr,
  input  logic [BW-1:0] reqBit,
  input  logic [NB-1:0] senseData,
  output logic          expire,
  output logic [AW-1:0] addrOut,
  output logic [NB-1:0] pulseOut,
  output logic [1:0]    supplySel,
  output logic          chipEnable,
  output logic          outClamp,
  output logic          passFlag,
  output logic          rejectFlag
);

  logic [CW-1:0] tickCnt;
  logic [BW-1:0] bitSel;

  // a zero-length phase falls through in one clock
  assign expire = (phaseLen == '0) || (usTick && (tickCnt == phaseLen - CW'(1)));

  always_ff @(posedge clk) begin
    if (!rstN)                    tickCnt <= '0;
    else if (stb.latch || expire) tickCnt <= '0;
    else if (usTick)              tickCnt <= tickCnt + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrOut <= '0;
      bitSel  <= '0;
    end else if (stb.latch) begin
      addrOut <= reqAddr;
      bitSel  <= reqBit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.latch) begin
      passFlag   <= 1'b0;
      rejectFlag <= 1'b0;
    end else if (stb.sample) begin
      passFlag   <= ~senseData[bitSel];
      rejectFlag <= senseData[bitSel];
    end
  end

  assign pulseOut   = stb.pulseEn ? (NB'(1) << bitSel) : '0;
  assign supplySel  = stb.supply;
  assign chipEnable = stb.chipEn;
  assign outClamp   = stb.clamp;

endmodule

// File: rtl/fuse_prog_seq.sv
module fuse_prog_seq
  import fps_pkg::*;
#(
  parameter int ADDR_W       = 9,
  parameter int NUM_BITS     = 4,
  parameter int SETUP_TICKS  = 2,
  parameter int RISE_TICKS   = 5,
  parameter int DELAY1_TICKS = 10,
  parameter int PULSE_TICKS  = 100,
  parameter int DELAY2_TICKS = 5,
  parameter int FALL_TICKS   = 5,
  parameter int VERIFY_TICKS = 5,
  parameter int DUTY_PCT     = 30,
  localparam int BW = (NUM_BITS > 1) ? $clog2(NUM_BITS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              usTick,
  input  logic              start,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BW-1:0]     reqBit,
  input  logic [NUM_BITS-1:0] senseData,
  output logic [ADDR_W-1:0] addrOut,
  output logic [1:0]        supplySel,
  output logic              chipEnable,
  output logic              outClamp,
  output logic [NUM_BITS-1:0] pulseOut,
  output logic              busy,
  output logic              done,
  output logic              passFlag,
  output logic              rejectFlag
);

  localparam int ACTIVE_TICKS = SETUP_TICKS + RISE_TICKS + DELAY1_TICKS + PULSE_TICKS
                              + DELAY2_TICKS + FALL_TICKS + VERIFY_TICKS;
  localparam int MIN_SPAN     = (PULSE_TICKS * 100 + DUTY_PCT - 1) / DUTY_PCT;
  localparam int COOL_TICKS   = (MIN_SPAN > ACTIVE_TICKS) ? (MIN_SPAN - ACTIVE_TICKS) : 0;
  localparam int CW           = $clog2(ACTIVE_TICKS + COOL_TICKS + 1);

  strobe_t       stb;
  logic [CW-1:0] phaseLen;
  logic          expire;

  fps_ctrl #(
    .CW(CW), .SETUP_TICKS(SETUP_TICKS), .RISE_TICKS(RISE_TICKS),
    .DELAY1_TICKS(DELAY1_TICKS), .PULSE_TICKS(PULSE_TICKS),
    .DELAY2_TICKS(DELAY2_TICKS), .FALL_TICKS(FALL_TICKS),
    .VERIFY_TICKS(VERIFY_TICKS), .COOL_TICKS(COOL_TICKS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .expire(expire),
    .stb(stb), .phaseLen(phaseLen), .busy(busy), .done(done)
  );

  fps_dpath #(.AW(ADDR_W), .NB(NUM_BITS), .CW(CW)) dpath_i (
    .clk(clk), .rstN(rstN), .usTick(usTick), .stb(stb), .phaseLen(phaseLen),
    .reqAddr(reqAddr), .reqBit(reqBit), .senseData(senseData),
    .expire(expire), .addrOut(addrOut), .pulseOut(pulseOut),
    .supplySel(supplySel), .chipEnable(chipEnable), .outClamp(outClamp),
    .passFlag(passFlag), .rejectFlag(rejectFlag)
  );

endmodule

// File: rtl/fps_checker.sv
module fps_checker #(
  parameter int AW = 9,
  parameter int NB = 4
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] addrOut,
  input logic [NB-1:0] pulseOut,
  input logic [1:0]    supplySel,
  input logic          chipEnable,
  input logic          passFlag,
  input logic          rejectFlag
);

  logic       pulsePrev;
  logic [1:0] riseCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulsePrev <= 1'b0;
      riseCnt   <= '0;
    end else begin
      pulsePrev <= (pulseOut != '0);
      if (!busy)
        riseCnt <= '0;
      else if ((pulseOut != '0) && !pulsePrev && (riseCnt != 2'd3))
        riseCnt <= riseCnt + 2'd1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (pulseOut == '0) && !chipEnable); // R1
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done && start) |=> $stable(addrOut)); // R2
  AST_PULSE_AT_PROG: assert property (@(posedge clk) disable iff (!rstN)
    (pulseOut != '0) |-> (supplySel == 2'b01) && !chipEnable); // R3
  AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pulseOut)); // R4
  AST_VERIFY_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    chipEnable |-> (supplySel == 2'b10) && (pulseOut == '0)); // R5
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    riseCnt < 2'd2); // R6
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(passFlag && rejectFlag)); // R6
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(addrOut)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9

endmodule

bind fuse_prog_seq fps_checker #(.AW(ADDR_W), .NB(NUM_BITS)) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .addrOut(addrOut), .pulseOut(pulseOut), .supplySel(supplySel),
  .chipEnable(chipEnable), .passFlag(passFlag), .rejectFlag(rejectFlag)
);

// File: tb/fuse_prog_seq_tb_top.sv
`timescale 1ns/1ps
module fuse_prog_seq_tb_top;

  localparam int SETUP = 1, RISE = 2, D1 = 3, PW = 4, D2 = 2, FALL = 2, VFY = 2, DUTY = 20;
  localparam int MIN_SPAN = (PW * 100 + DUTY - 1) / DUTY;
  localparam int ACTIVE = SETUP + RISE + D1 + PW + D2 + FALL + VFY;
  localparam int SPAN = (MIN_SPAN > ACTIVE) ? MIN_SPAN : ACTIVE;

  logic clk = 1'b0, rstN = 1'b0, usTick = 1'b0, start = 1'b0;
  logic [8:0] reqAddr = '0;
  logic [1:0] reqBit = '0;
  logic [3:0] senseData = 4'hF;
  logic [8:0] addrOut;
  logic [1:0] supplySel;
  logic chipEnable, outClamp, busy, done, passFlag, rejectFlag;
  logic [3:0] pulseOut;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  fuse_prog_seq #(
    .SETUP_TICKS(SETUP), .RISE_TICKS(RISE), .DELAY1_TICKS(D1), .PULSE_TICKS(PW),
    .DELAY2_TICKS(D2), .FALL_TICKS(FALL), .VERIFY_TICKS(VFY), .DUTY_PCT(DUTY)
  ) dut_i (
    .clk(clk), .rstN(rstN), .usTick(usTick), .start(start), .reqAddr(reqAddr),
    .reqBit(reqBit), .senseData(senseData), .addrOut(addrOut), .supplySel(supplySel),
    .chipEnable(chipEnable), .outClamp(outClamp), .pulseOut(pulseOut), .busy(busy),
    .done(done), .passFlag(passFlag), .rejectFlag(rejectFlag)
  );

  always #2 clk = ~clk;

  initial begin : tick_gen
    int div = 0;
    forever begin
      @(negedge clk);
      div = (div + 1) % 4;
      usTick = (div == 0);
    end
  end

  // monitor state
  bit monEn = 0, seenPulse, seenVfy, prevPulse;
  int totTicks, pulseTicks, setupTicks, preTicks, postHigh, postLow, vfyTicks;
  int pulseRises, pulseBad, addrBad, doneCnt;
  logic [8:0] expAddr;
  logic [3:0] expHot;

  task automatic clearMon(input logic [8:0] a, input logic [1:0] b);
    totTicks = 0; pulseTicks = 0; setupTicks = 0; preTicks = 0; postHigh = 0;
    postLow = 0; vfyTicks = 0; pulseRises = 0; pulseBad = 0; addrBad = 0; doneCnt = 0;
    seenPulse = 0; seenVfy = 0; prevPulse = 0;
    expAddr = a; expHot = 4'(1) << b;
  endtask

  always @(negedge clk) begin
    if (monEn) begin
      if (pulseOut != '0) begin
        if (!prevPulse) pulseRises++;
        if (pulseOut != expHot) pulseBad++;
        seenPulse = 1;
        if (usTick) pulseTicks++;
      end
      if (chipEnable) seenVfy = 1;
      if (usTick && busy && !done) begin
        totTicks++;
        if (pulseOut == '0) begin
          if (chipEnable && supplySel == 2'b10) vfyTicks++;
          else if (!seenPulse) begin
            if (supplySel == 2'b00 && !chipEnable && outClamp) setupTicks++;
            if (supplySel == 2'b01 && !chipEnable) preTicks++;
          end else if (!seenVfy) begin
            if (supplySel == 2'b01) postHigh++;
            if (supplySel == 2'b00) postLow++;
          end
        end
      end
      if (busy && addrOut !== expAddr) addrBad++;
      if (done) doneCnt++;
      prevPulse = (pulseOut != '0);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    check(busy == 0 && done == 0, "R1 busy/done", {busy, done}, 0);
    check(passFlag == 0 && rejectFlag == 0, "R1 flags", {passFlag, rejectFlag}, 0);
    check(supplySel == 2'b00 && chipEnable == 0 && outClamp == 0, "R1 levels",
          {supplySel, chipEnable, outClamp}, 0);
    check(pulseOut == '0 && addrOut == '0, "R1 pulse/addr", {pulseOut, addrOut}, 0);
  endtask

  task automatic run_seq(input logic [8:0] a, input logic [1:0] b, input logic [3:0] sense,
                         input bit expPass, input bit disturb);
    int waitCnt = 0;
    bit disturbed = 0;
    @(negedge clk);
    clearMon(a, b);
    senseData = sense;
    monEn = 1;
    start = 1; reqAddr = a; reqBit = b;
    @(negedge clk);
    start = 0; reqAddr = ~a; reqBit = b + 2'd1;
    check(busy == 1, "R2 start accepted when idle", busy, 1);
    check(passFlag == 0 && rejectFlag == 0, "R9 flags cleared on start",
          {passFlag, rejectFlag}, 0);
    while (doneCnt == 0 && waitCnt < 2000) begin
      @(negedge clk);
      waitCnt++;
      if (disturb && !disturbed && pulseOut != '0) begin
        start = 1; disturbed = 1;
      end else start = 0;
    end
    start = 0;
    repeat (10) @(negedge clk);
    check(doneCnt == 1, "R9 one done pulse", doneCnt, 1);
    check(passFlag == expPass && rejectFlag == !expPass, "R6 verdict",
          {passFlag, rejectFlag}, {expPass, !expPass});
    check(setupTicks == SETUP, "R3 setup ticks at low level", setupTicks, SETUP);
    check(preTicks == RISE + D1, "R3 program-level ticks before pulse", preTicks, RISE + D1);
    check(pulseTicks == PW, "R4 pulse width", pulseTicks, PW);
    check(pulseBad == 0, "R4 pulse on selected line only", pulseBad, 0);
    check(postHigh == D2 && postLow == FALL, "R5 post-pulse levels",
          postHigh * 100 + postLow, D2 * 100 + FALL);
    check(vfyTicks == VFY, "R5 verify window", vfyTicks, VFY);
    check(pulseRises == 1, "R6 single pulse", pulseRises, 1);
    check(totTicks == SPAN && totTicks >= MIN_SPAN, "R7 sequence span with cool-down",
          totTicks, SPAN);
    check(addrBad == 0, "R8 address held", addrBad, 0);
    monEn = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    test_reset();
    rstN = 1;
    test_reset();
    run_seq(9'h1A5, 2'd2, 4'b1011, 1'b1, 1'b0);  // R6 pass, other bits high
    run_seq(9'h003, 2'd0, 4'b0001, 1'b0, 1'b0);  // R6 reject, other bits low
    run_seq(9'h1FF, 2'd3, 4'b0111, 1'b1, 1'b1);  // R2 start during pulse ignored
    run_seq(9'h0AA, 2'd1, 4'b0010, 1'b0, 1'b0);  // R9 flags cleared then reject
    check(supplySel == 2'b00 && !busy, "R1 back to idle", {supplySel, busy}, 0);
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule